// File: doc/BRIEF.md
# Bridge System Error Reporting Unit

This unit sits beside the data-path engines of a two-sided bus bridge. It gathers every condition that may count as a system error and decides, once per clock, whether to pull the primary-side active-low system error line. The conditions are a sampled secondary-side error input, abort and parity pulses from the posted-write engine, a master-timeout pulse, and retry pulses from the posted-write, delayed-write and delayed-read engines. Each engine has its own retry counter. When a transaction has been retried a programmable number of times it is abandoned, and the abandonment becomes an error event of its own.

Every event passes through several gating layers before it can reach the output. These are a global enable in the command register, a forwarding enable for the secondary input, a disable bit for each maskable event, and a dedicated enable for master timeout. Software writes these enables through simple write-strobe ports. Each qualified assertion is recorded in sticky status bits: a signaled bit, a received bit for the secondary input, and an eight-bit cause vector. Software clears any of these bits by writing a one to it.

Top module: `bridge_syserr_unit`

## Requirements
- R1: After reset, `serr_n_o` is 1, `sts_sig_o`, `sts_rcv_o` and `cause_o` are 0, and the command, bridge-control and disable registers are 0.
- R2: No event can drive `serr_n_o` low while the command enable (written from `cmd_serr_en_i` with `cmd_we_i`) is 0.
- R3: `serr_n_o` is low for exactly the one clock that follows each edge at which at least one qualified event was sampled, and is 1 otherwise. Several events sampled at the same edge give one low clock.
- R4: `sts_sig_o` becomes 1 at the same edge that drives `serr_n_o` low.
- R5: A low `sec_serr_n_i` is a qualified event, recorded in `cause_o[7]`, only when the forward enable (`bctl_fwd_en_i`) is 1.
- R6: `sts_rcv_o` is set at every edge where `sec_serr_n_i` is sampled low, whatever the enables are.
- R7: Setting bit i of the disable register (`dis_mask_i`, bits 0..5) masks the event recorded in `cause_o[i]`. The bits map as follows: 0 posted-write target abort, 1 posted-write master abort, 2 posted-write retry exhaustion, 3 posted-write parity error, 4 delayed-write retry exhaustion, 5 delayed-read retry exhaustion.
- R8: Master timeout (`mto_i`, `cause_o[6]`) is qualified only when the bridge-control enable `bctl_mto_en_i` is 1. The disable register has no effect on it.
- R9: Each engine counts its own retry pulses. The RETRY_LIMIT-th pulse since that engine's counter was last cleared is an exhaustion event, and that counter then restarts from zero.
- R10: A done pulse clears that engine's counter. A retry and a done at the same edge count no retry and raise no event.
- R11: `cause_o` bits are set only by qualified events and hold their value until cleared.
- R12: Writing 1 to a bit of `clr_cause_i`, `clr_sig_i` or `clr_rcv_i` clears that bit at the next edge. A set that happens at the same edge takes priority over the clear.
- R13: Register writes take effect at the following edge. An event sampled at the same edge as a write is judged with the old settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sec_serr_n_i | input | 1 | Sampled secondary system error, active low |
| pw_tabort_i | input | 1 | Posted write target abort pulse |
| pw_mabort_i | input | 1 | Posted write master abort pulse |
| pw_parity_i | input | 1 | Posted write target-bus parity error pulse |
| pw_retry_i | input | 1 | Posted write target retry pulse |
| pw_done_i | input | 1 | Posted write complete or discarded |
| dw_retry_i | input | 1 | Delayed write target retry pulse |
| dw_done_i | input | 1 | Delayed write complete or discarded |
| dr_retry_i | input | 1 | Delayed read target retry pulse |
| dr_done_i | input | 1 | Delayed read complete or discarded |
| mto_i | input | 1 | Delayed transaction master timeout pulse |
| cmd_we_i | input | 1 | Command register write strobe |
| cmd_serr_en_i | input | 1 | Command system error enable write data |
| bctl_we_i | input | 1 | Bridge control write strobe |
| bctl_fwd_en_i | input | 1 | Secondary forward enable write data |
| bctl_mto_en_i | input | 1 | Master timeout enable write data |
| dis_we_i | input | 1 | Event disable register write strobe |
| dis_mask_i | input | 6 | Event disable write data |
| clr_sig_i | input | 1 | Write-one-to-clear for signaled bit |
| clr_rcv_i | input | 1 | Write-one-to-clear for received bit |
| clr_cause_i | input | 8 | Write-one-to-clear for cause bits |
| serr_n_o | output | 1 | Primary system error, active low |
| sts_sig_o | output | 1 | Signaled system error status |
| sts_rcv_o | output | 1 | Received secondary system error status |
| cause_o | output | 8 | Sticky cause status |

## Verification
The bench builds the unit with RETRY_LIMIT set to 4, so retry exhaustion, restart after exhaustion and clearing by done take a handful of cycles instead of sixteen million. With this value the bench also reaches the boundary one pulse short of the limit and the case of a retry and a done at the same edge. The default limit changes only the counter width, and elaborating the RTL with its defaults covers it.

// File: rtl/bsu_pkg.sv
package bsu_pkg;
   localparam int N_EV         = 8;
   localparam int N_MASK       = 6;
   localparam int EV_PW_TABORT = 0;
   localparam int EV_PW_MABORT = 1;
   localparam int EV_PW_DISC   = 2;
   localparam int EV_PW_PARITY = 3;
   localparam int EV_DW_DISC   = 4;
   localparam int EV_DR_DISC   = 5;
   localparam int EV_MTO       = 6;
   localparam int EV_SEC       = 7;
   localparam int N_ENGINE     = 3;

   typedef struct packed {
      logic mto_en;
      logic fwd_en;
   } bctl_t;
endpackage

// File: rtl/bsu_retry_limiter.sv
module bsu_retry_limiter #(
   parameter int LIMIT = 2**24
) (
   input  logic clk,
   input  logic rst_n,
   input  logic retry_i,
   input  logic done_i,
   output logic exhaust_o
);
   generate
      if (LIMIT < 1) begin : g_bad_limit
         $error("bsu_retry_limiter: LIMIT must be at least 1");
      end
      if (LIMIT == 1) begin : g_direct
         assign exhaust_o = retry_i & ~done_i;
      end else begin : g_count
         localparam int CW = $clog2(LIMIT);
         localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);
         logic [CW-1:0] cnt_q;
         logic          hit;
         assign hit       = (cnt_q == LAST);
         assign exhaust_o = retry_i & ~done_i & hit;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       cnt_q <= '0;
            else if (done_i)  cnt_q <= '0;
            else if (retry_i) cnt_q <= hit ? '0 : cnt_q + CW'(1);
         end
      end
   endgenerate
endmodule

// File: rtl/bsu_qualifier.sv
module bsu_qualifier
   import bsu_pkg::*;
(
   input  logic [N_EV-1:0]   raw_i,
   input  logic              serr_en_i,
   input  bctl_t             bctl_i,
   input  logic [N_MASK-1:0] dis_i,
   output logic [N_EV-1:0]   qual_o
);
   generate
      if (N_MASK != EV_MTO) begin : g_bad_map
         $error("bsu_qualifier: maskable events must precede master timeout");
      end
      for (genvar i = 0; i < N_MASK; i++) begin : g_mask
         assign qual_o[i] = serr_en_i & raw_i[i] & ~dis_i[i];
      end
   endgenerate
   assign qual_o[EV_MTO] = serr_en_i & bctl_i.mto_en & raw_i[EV_MTO];
   assign qual_o[EV_SEC] = serr_en_i & bctl_i.fwd_en & raw_i[EV_SEC];
endmodule

// File: rtl/bsu_sticky.sv
module bsu_sticky #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set_i,
   input  logic [W-1:0] clr_i,
   output logic [W-1:0] q_o
);
   generate
      if (W < 1) begin : g_bad_w
         $error("bsu_sticky: W must be positive");
      end
      for (genvar b = 0; b < W; b++) begin : g_bit
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        q_o[b] <= 1'b0;
            else if (set_i[b]) q_o[b] <= 1'b1;
            else if (clr_i[b]) q_o[b] <= 1'b0;
         end
      end
   endgenerate
endmodule

// File: rtl/bridge_syserr_unit.sv
module bridge_syserr_unit
   import bsu_pkg::*;
#(
   parameter int RETRY_LIMIT = 2**24
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sec_serr_n_i,
   input  logic              pw_tabort_i,
   input  logic              pw_mabort_i,
   input  logic              pw_parity_i,
   input  logic              pw_retry_i,
   input  logic              pw_done_i,
   input  logic              dw_retry_i,
   input  logic              dw_done_i,
   input  logic              dr_retry_i,
   input  logic              dr_done_i,
   input  logic              mto_i,
   input  logic              cmd_we_i,
   input  logic              cmd_serr_en_i,
   input  logic              bctl_we_i,
   input  logic              bctl_fwd_en_i,
   input  logic              bctl_mto_en_i,
   input  logic              dis_we_i,
   input  logic [N_MASK-1:0] dis_mask_i,
   input  logic              clr_sig_i,
   input  logic              clr_rcv_i,
   input  logic [N_EV-1:0]   clr_cause_i,
   output logic              serr_n_o,
   output logic              sts_sig_o,
   output logic              sts_rcv_o,
   output logic [N_EV-1:0]   cause_o
);
   localparam int ST_W = N_EV + 2;

   logic              cmd_en_q;
   bctl_t             bctl_q;
   logic [N_MASK-1:0] dis_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_en_q <= 1'b0;
         bctl_q   <= '0;
         dis_q    <= '0;
      end else begin
         if (cmd_we_i)  cmd_en_q <= cmd_serr_en_i;
         if (bctl_we_i) bctl_q   <= '{mto_en: bctl_mto_en_i, fwd_en: bctl_fwd_en_i};
         if (dis_we_i)  dis_q    <= dis_mask_i;
      end
   end

   logic [N_ENGINE-1:0] retry_v, done_v, exh_v;
   assign retry_v = {dr_retry_i, dw_retry_i, pw_retry_i};
   assign done_v  = {dr_done_i,  dw_done_i,  pw_done_i};

   generate
      for (genvar e = 0; e < N_ENGINE; e++) begin : g_eng
         bsu_retry_limiter #(.LIMIT(RETRY_LIMIT)) u_lim (
            .clk       (clk),
            .rst_n     (rst_n),
            .retry_i   (retry_v[e]),
            .done_i    (done_v[e]),
            .exhaust_o (exh_v[e])
         );
      end
   endgenerate

   logic [N_EV-1:0] raw, qual;
   always_comb begin
      raw               = '0;
      raw[EV_PW_TABORT] = pw_tabort_i;
      raw[EV_PW_MABORT] = pw_mabort_i;
      raw[EV_PW_DISC]   = exh_v[0];
      raw[EV_PW_PARITY] = pw_parity_i;
      raw[EV_DW_DISC]   = exh_v[1];
      raw[EV_DR_DISC]   = exh_v[2];
      raw[EV_MTO]       = mto_i;
      raw[EV_SEC]       = ~sec_serr_n_i;
   end

   bsu_qualifier u_qual (
      .raw_i     (raw),
      .serr_en_i (cmd_en_q),
      .bctl_i    (bctl_q),
      .dis_i     (dis_q),
      .qual_o    (qual)
   );

   logic any_qual;
   assign any_qual = |qual;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) serr_n_o <= 1'b1;
      else        serr_n_o <= ~any_qual;
   end

   logic [ST_W-1:0] st_set, st_clr, st_q;
   assign st_set = {raw[EV_SEC], any_qual, qual};
   assign st_clr = {clr_rcv_i, clr_sig_i, clr_cause_i};

   bsu_sticky #(.W(ST_W)) u_sts (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (st_set),
      .clr_i (st_clr),
      .q_o   (st_q)
   );

   assign cause_o   = st_q[N_EV-1:0];
   assign sts_sig_o = st_q[N_EV];
   assign sts_rcv_o = st_q[N_EV+1];
endmodule

// File: rtl/bsu_checker.sv
module bsu_checker (
   input logic       clk,
   input logic       rst_n,
   input logic       serr_n_o,
   input logic       sts_sig_o,
   input logic       sts_rcv_o,
   input logic [7:0] cause_o,
   input logic       sec_serr_n_i,
   input logic       clr_sig_i,
   input logic       cmd_en_q
);
   // R4
   sig_with_assert_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !serr_n_o |-> sts_sig_o);

   // R11
   cause_with_assert_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !serr_n_o |-> (cause_o != 8'h00));

   // R2
   global_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !serr_n_o |-> $past(cmd_en_q));

   // R6
   rcv_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !sec_serr_n_i |=> sts_rcv_o);

   // R12
   sig_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sts_sig_o && !clr_sig_i) |=> sts_sig_o);
endmodule

bind bridge_syserr_unit bsu_checker u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .serr_n_o     (serr_n_o),
   .sts_sig_o    (sts_sig_o),
   .sts_rcv_o    (sts_rcv_o),
   .cause_o      (cause_o),
   .sec_serr_n_i (sec_serr_n_i),
   .clr_sig_i    (clr_sig_i),
   .cmd_en_q     (cmd_en_q)
);

// File: tb/bridge_syserr_unit_bench.sv
`timescale 1ns/1ps
module bridge_syserr_unit_bench;
   localparam int LIM = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sec_serr_n_i = 1'b1;
   logic pw_tabort_i = 0, pw_mabort_i = 0, pw_parity_i = 0;
   logic pw_retry_i = 0, pw_done_i = 0, dw_retry_i = 0, dw_done_i = 0;
   logic dr_retry_i = 0, dr_done_i = 0, mto_i = 0;
   logic cmd_we_i = 0, cmd_serr_en_i = 0, bctl_we_i = 0, bctl_fwd_en_i = 0;
   logic bctl_mto_en_i = 0, dis_we_i = 0;
   logic [5:0] dis_mask_i = '0;
   logic clr_sig_i = 0, clr_rcv_i = 0;
   logic [7:0] clr_cause_i = '0;
   logic serr_n_o, sts_sig_o, sts_rcv_o;
   logic [7:0] cause_o;

   always #2 clk = ~clk;

   bridge_syserr_unit #(.RETRY_LIMIT(LIM)) u_bridge_syserr_unit (.*);

   int n_chk = 0, n_fail = 0;
   bit done_flag = 0;

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   // behavioural reference model
   bit       m_en = 0, m_fwd = 0, m_mto = 0;
   bit [5:0] m_dis = 0;
   int       m_cnt [3] = '{0, 0, 0};
   bit       m_serr_n = 1, m_sig = 0, m_rcv = 0;
   bit [7:0] m_cause = 0;
   bit       cmp_on = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_en = 0; m_fwd = 0; m_mto = 0; m_dis = 0;
         m_cnt = '{0, 0, 0};
         m_serr_n = 1; m_sig = 0; m_rcv = 0; m_cause = 0;
      end else begin
         bit [7:0] ev, q;
         bit rt [3], dn [3];
         int slot [3];
         ev = 0; q = 0;
         rt = '{pw_retry_i, dw_retry_i, dr_retry_i};
         dn = '{pw_done_i, dw_done_i, dr_done_i};
         slot = '{2, 4, 5};
         ev[0] = pw_tabort_i; ev[1] = pw_mabort_i; ev[3] = pw_parity_i;
         ev[6] = mto_i; ev[7] = !sec_serr_n_i;
         for (int k = 0; k < 3; k++) begin
            if (dn[k]) m_cnt[k] = 0;
            else if (rt[k]) begin
               m_cnt[k]++;
               if (m_cnt[k] == LIM) begin
                  ev[slot[k]] = 1;
                  m_cnt[k] = 0;
               end
            end
         end
         if (m_en) begin
            for (int i = 0; i < 6; i++) q[i] = ev[i] && !m_dis[i];
            q[6] = ev[6] && m_mto;
            q[7] = ev[7] && m_fwd;
         end
         m_cause  = (m_cause & ~clr_cause_i) | q;
         m_sig    = (q != 0) ? 1'b1 : (m_sig && !clr_sig_i);
         m_rcv    = ev[7] ? 1'b1 : (m_rcv && !clr_rcv_i);
         m_serr_n = (q == 0);
         if (cmd_we_i)  m_en = cmd_serr_en_i;
         if (bctl_we_i) begin m_fwd = bctl_fwd_en_i; m_mto = bctl_mto_en_i; end
         if (dis_we_i)  m_dis = dis_mask_i;
      end
   end

   always @(negedge clk) begin
      if (cmp_on && rst_n && !done_flag) begin
         chk(serr_n_o === m_serr_n, "R3 model serr_n_o", serr_n_o, m_serr_n);
         chk(sts_sig_o === m_sig, "R4 model sts_sig_o", sts_sig_o, m_sig);
         chk(sts_rcv_o === m_rcv, "R6 model sts_rcv_o", sts_rcv_o, m_rcv);
         chk(cause_o === m_cause, "R11 model cause_o", cause_o, m_cause);
      end
   end

   task automatic step(input int n = 1);
      for (int i = 0; i < n; i++) begin
         @(posedge clk);
         @(negedge clk);
      end
   endtask

   task automatic idle();
      sec_serr_n_i = 1; pw_tabort_i = 0; pw_mabort_i = 0; pw_parity_i = 0;
      pw_retry_i = 0; pw_done_i = 0; dw_retry_i = 0; dw_done_i = 0;
      dr_retry_i = 0; dr_done_i = 0; mto_i = 0;
      cmd_we_i = 0; bctl_we_i = 0; dis_we_i = 0;
      clr_sig_i = 0; clr_rcv_i = 0; clr_cause_i = 0;
   endtask

   task automatic wr_cfg(input bit en, input bit fwd, input bit mto, input bit [5:0] dis);
      cmd_we_i = 1; cmd_serr_en_i = en;
      bctl_we_i = 1; bctl_fwd_en_i = fwd; bctl_mto_en_i = mto;
      dis_we_i = 1; dis_mask_i = dis;
      step(); idle();
   endtask

   task automatic clr_all();
      clr_sig_i = 1; clr_rcv_i = 1; clr_cause_i = 8'hFF;
      step(); idle();
   endtask

   task automatic finish_run();
      if (!done_flag) begin
         done_flag = 1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   endtask

   initial begin
      #(200000 * 4);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finish_run();
   end

   initial begin
      step(3);
      rst_n = 1;
      cmp_on = 1;
      // R1 reset state
      chk(serr_n_o === 1'b1, "R1 serr_n_o", serr_n_o, 1);
      chk({sts_sig_o, sts_rcv_o, cause_o} === 10'd0, "R1 status", {sts_sig_o, sts_rcv_o, cause_o}, 0);

      // R2 disabled globally: all other enables on
      pw_tabort_i = 1; mto_i = 1;
      bctl_we_i = 1; bctl_fwd_en_i = 1; bctl_mto_en_i = 1; step(); idle();
      sec_serr_n_i = 0; pw_tabort_i = 1; step(); idle();
      chk(serr_n_o === 1'b1, "R2 no assert without enable", serr_n_o, 1);
      chk(cause_o === 8'h00, "R2 cause untouched", cause_o, 0);
      chk(sts_rcv_o === 1'b1, "R6 received without enable", sts_rcv_o, 1);

      // R13 write and event same edge: old (disabled) value used
      cmd_we_i = 1; cmd_serr_en_i = 1; pw_tabort_i = 1; step(); idle();
      chk(serr_n_o === 1'b1, "R13 old enable applies", serr_n_o, 1);
      clr_all();

      // R3/R4/R11 single event
      wr_cfg(1, 0, 0, 6'h00);
      pw_tabort_i = 1; step(); idle();
      chk(serr_n_o === 1'b0, "R3 low after event", serr_n_o, 0);
      chk(sts_sig_o === 1'b1, "R4 signaled", sts_sig_o, 1);
      chk(cause_o === 8'h01, "R11 cause bit0", cause_o, 8'h01);
      step();
      chk(serr_n_o === 1'b1, "R3 one clock only", serr_n_o, 1);
      chk(cause_o === 8'h01, "R11 sticky", cause_o, 8'h01);
      // R3 simultaneous events give one low clock
      pw_mabort_i = 1; pw_parity_i = 1; step(); idle();
      chk(serr_n_o === 1'b0, "R3 simultaneous low", serr_n_o, 0);
      step();
      chk(serr_n_o === 1'b1, "R3 simultaneous single clock", serr_n_o, 1);
      clr_all();
      chk({sts_sig_o, sts_rcv_o, cause_o} === 10'd0, "R12 clear all", {sts_sig_o, sts_rcv_o, cause_o}, 0);

      // R5 forward enable
      sec_serr_n_i = 0; step(); idle();
      chk(serr_n_o === 1'b1, "R5 not forwarded", serr_n_o, 1);
      chk(sts_rcv_o === 1'b1, "R6 received", sts_rcv_o, 1);
      wr_cfg(1, 1, 0, 6'h00);
      sec_serr_n_i = 0; step(); idle();
      chk(serr_n_o === 1'b0, "R5 forwarded", serr_n_o, 0);
      chk(cause_o[7] === 1'b1, "R5 cause bit7", cause_o[7], 1);
      clr_all();

      // R7 disable bits
      wr_cfg(1, 0, 0, 6'h01);
      pw_tabort_i = 1; step(); idle();
      chk(serr_n_o === 1'b1, "R7 masked tabort", serr_n_o, 1);
      pw_mabort_i = 1; step(); idle();
      chk(serr_n_o === 1'b0, "R7 unmasked mabort", serr_n_o, 0);
      chk(cause_o === 8'h02, "R7 cause bit1", cause_o, 8'h02);
      clr_all();

      // R8 master timeout
      mto_i = 1; step(); idle();
      chk(serr_n_o === 1'b1, "R8 mto without enable", serr_n_o, 1);
      wr_cfg(1, 0, 1, 6'h3F);
      mto_i = 1; step(); idle();
      chk(serr_n_o === 1'b0, "R8 mto with enable ignores disable", serr_n_o, 0);
      chk(cause_o === 8'h40, "R8 cause bit6", cause_o, 8'h40);
      clr_all();

      // R9 posted write exhaustion
      wr_cfg(1, 0, 0, 6'h00);
      for (int i = 0; i < LIM - 1; i++) begin
         pw_retry_i = 1; step(); idle();
         chk(serr_n_o === 1'b1, "R9 below limit", serr_n_o, 1);
      end
      pw_retry_i = 1; step(); idle();
      chk(serr_n_o === 1'b0, "R9 limit reached", serr_n_o, 0);
      chk(cause_o === 8'h04, "R9 cause bit2", cause_o, 8'h04);
      clr_all();
      for (int i = 0; i < LIM - 1; i++) begin pw_retry_i = 1; step(); idle(); end
      chk(cause_o === 8'h00, "R9 counter restarted", cause_o, 0);
      pw_done_i = 1; step(); idle();

      // R10 done clears delayed write counter
      for (int i = 0; i < LIM - 2; i++) begin dw_retry_i = 1; step(); idle(); end
      dw_done_i = 1; step(); idle();
      for (int i = 0; i < LIM - 1; i++) begin dw_retry_i = 1; step(); idle(); end
      chk(cause_o === 8'h00, "R10 done cleared count", cause_o, 0);
      dw_retry_i = 1; step(); idle();
      chk(cause_o === 8'h10, "R9 delayed write cause bit4", cause_o, 8'h10);
      clr_all();

      // R10 retry and done together on delayed read
      for (int i = 0; i < LIM - 1; i++) begin dr_retry_i = 1; step(); idle(); end
      dr_retry_i = 1; dr_done_i = 1; step(); idle();
      chk(serr_n_o === 1'b1, "R10 retry with done no event", serr_n_o, 1);
      for (int i = 0; i < LIM; i++) begin dr_retry_i = 1; step(); idle(); end
      chk(cause_o === 8'h20, "R9 delayed read cause bit5", cause_o, 8'h20);
      clr_all();

      // R12 set wins over clear
      pw_parity_i = 1; clr_cause_i = 8'h08; clr_sig_i = 1; step(); idle();
      chk(cause_o === 8'h08, "R12 set beats clear", cause_o, 8'h08);
      chk(sts_sig_o === 1'b1, "R12 signaled set beats clear", sts_sig_o, 1);
      clr_cause_i = 8'h08; step(); idle();
      chk(cause_o === 8'h00, "R12 write one clears", cause_o, 0);
      clr_all();

      // mixed traffic against the model
      for (int c = 0; c < 3000; c++) begin
         sec_serr_n_i = ($urandom_range(0, 7) != 0);
         pw_tabort_i  = ($urandom_range(0, 9) == 0);
         pw_mabort_i  = ($urandom_range(0, 9) == 0);
         pw_parity_i  = ($urandom_range(0, 9) == 0);
         pw_retry_i   = ($urandom_range(0, 1) == 0);
         dw_retry_i   = ($urandom_range(0, 1) == 0);
         dr_retry_i   = ($urandom_range(0, 1) == 0);
         pw_done_i    = ($urandom_range(0, 11) == 0);
         dw_done_i    = ($urandom_range(0, 11) == 0);
         dr_done_i    = ($urandom_range(0, 11) == 0);
         mto_i        = ($urandom_range(0, 9) == 0);
         cmd_we_i     = ($urandom_range(0, 15) == 0);
         cmd_serr_en_i = ($urandom_range(0, 3) != 0);
         bctl_we_i    = ($urandom_range(0, 15) == 0);
         bctl_fwd_en_i = $urandom_range(0, 1);
         bctl_mto_en_i = $urandom_range(0, 1);
         dis_we_i     = ($urandom_range(0, 15) == 0);
         dis_mask_i   = 6'($urandom);
         clr_sig_i    = ($urandom_range(0, 5) == 0);
         clr_rcv_i    = ($urandom_range(0, 5) == 0);
         clr_cause_i  = ($urandom_range(0, 5) == 0) ? 8'($urandom) : 8'h00;
         step();
      end
      idle();
      step(2);
      finish_run();
   end
endmodule